// File: doc/BRIEF.md
# Dual-Channel Edge-Triggered Input Capture

This block watches two external input pins. When a pin shows the edge its channel is set to look for, the block copies the current value of a 16-bit free-running counter into that channel's capture register. In the same cycle it raises the channel's pending flag. A channel drives its interrupt line while both its pending flag and its interrupt enable are set.

One 8-bit control/status byte holds three things for each channel: the pending flag, the interrupt enable and a 2-bit edge selector. An edge selector of zero stops capture on that channel.

Firmware clears a pending flag by writing zero to it. Writing one to a pending flag has no effect. When the bus marks a read as the first half of a read-modify-write, the pending bits read back as one, so the write-back cannot clear a flag that was raised in the meantime.

The register port is a plain synchronous write strobe with a combinational read. No data streams through the block, so it has no valid/ready handshake and no back-pressure rules. Every pin is a plain control or status signal. The counter is an input and comes from outside the block.

Top module: `icap_ctrl`

## Requirements
- R1: The register map is as follows. Address 0 is the control/status byte: bit 7 is the channel 1 pending flag, bit 6 the channel 0 pending flag, bit 5 the channel 1 interrupt enable, bit 4 the channel 0 interrupt enable, bits 3:2 the channel 1 edge select and bits 1:0 the channel 0 edge select. Address 1 reads the channel 0 capture value and address 2 reads the channel 1 capture value. Address 3 reads zero. The read data is combinational from the address, and an 8-bit value is zero-extended to 16 bits.
- R2: After reset, every control/status bit, both capture registers and all interrupt outputs are zero.
- R3: Edge select 01 sets the flag and captures only on a low-to-high transition of the pin.
- R4: Edge select 10 sets the flag and captures only on a high-to-low transition of the pin.
- R5: Edge select 11 sets the flag and captures on either transition of the pin.
- R6: Edge select 00 stops the channel. Pin transitions then leave both its flag and its capture register unchanged.
- R7: A pin change that is set up before clock edge k becomes visible after edge k+2. At that point the flag is set and the capture register holds the counter value sampled at edge k+2. Neither is visible after edge k+1.
- R8: A write to address 0 clears every pending flag whose written bit is 0. A written 1 never sets or clears a flag. The enable and edge-select bits take the written value.
- R9: While the read-modify-write indication is high, a read of address 0 returns 1 in bits 7:6. All other bits read as stored.
- R10: Each channel's interrupt output is high exactly while that channel's flag and enable are both 1. The combined interrupt output is the OR of the two channel outputs.
- R11: If a valid edge and a clear-by-zero write reach the same flag at the same clock edge, the flag ends up set.
- R12: The capture registers are read-only. Writes to addresses 1 to 3 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | 16 | Free-running counter value to capture |
| cap_pin_i | input | 2 | Asynchronous capture pins; bit 0 is channel 0 |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe, acts at the clock edge |
| reg_rmw | input | 1 | Marks the current read as part of a read-modify-write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| irq_ch | output | 2 | Per-channel interrupt level |
| irq_any | output | 1 | OR of both channel interrupts |

## Verification
The bench drives each edge polarity against each selector setting. A design that decoded the selector wrongly would capture on the wrong transition, and one that ignored the stop code would keep overwriting its capture register. It checks the three-cycle latency one cycle early and again on time, which exposes a missing or extra synchronizer stage.

It writes ones over set and clear flags to catch a register that treats the flag bits as plain storage. It reads under the read-modify-write indication, where a wrong design would hand back a zero that then clears a live flag. It also lands a clearing write on the exact edge of a capture, where a wrong priority would lose the event.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int CNT_W = 16;
  localparam int NCH   = 2;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam logic [1:0] ADDR_CSR  = 2'd0;
  localparam logic [1:0] ADDR_CAP0 = 2'd1;
  localparam logic [1:0] ADDR_CAP1 = 2'd2;

  // bit positions in the control/status byte
  localparam int FLAG_LSB = 6;
  localparam int IE_LSB   = 4;
endpackage

// File: rtl/icap_edge_det.sv
module icap_edge_det
  import icap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_i,
  input  edge_sel_e sel_i,
  output logic      hit_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;
  logic                   rise;
  logic                   fall;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= cur;
    end
  end

  assign rise = cur & ~prev_q;
  assign fall = ~cur & prev_q;

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_BOTH: hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/icap_capture.sv
module icap_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] cap_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cap_o <= '0;
    else if (hit_i) cap_o <= cnt_i;
  end
endmodule

// File: rtl/icap_csr.sv
module icap_csr
  import icap_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_i,
  input  logic [7:0]                wdata_i,
  input  logic [NCH-1:0]            hit_i,
  output logic [NCH-1:0]            flag_o,
  output logic [NCH-1:0]            ie_o,
  output logic [NCH-1:0][SEL_W-1:0] sel_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic clr;
    assign clr = wr_i & ~wdata_i[FLAG_LSB+i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_o[i] <= 1'b0;
        ie_o[i]   <= 1'b0;
        sel_o[i]  <= '0;
      end else begin
        // a captured edge outranks a clear in the same cycle
        flag_o[i] <= hit_i[i] | (flag_o[i] & ~clr);
        if (wr_i) begin
          ie_o[i]  <= wdata_i[IE_LSB+i];
          sel_o[i] <= wdata_i[SEL_W*i +: SEL_W];
        end
      end
    end
  end
endmodule

// File: rtl/icap_ctrl.sv
module icap_ctrl
  import icap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [NCH-1:0]   cap_pin_i,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rmw,
  input  logic [7:0]       reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic [NCH-1:0]   irq_ch,
  output logic             irq_any
);
  logic [NCH-1:0]            hit;
  logic [NCH-1:0]            flag;
  logic [NCH-1:0]            ie;
  logic [NCH-1:0][SEL_W-1:0] sel;
  logic [CNT_W-1:0]          cap [NCH];
  logic                      csr_wr;
  logic [7:0]                csr_rd;

  assign csr_wr = reg_wr && (reg_addr == ADDR_CSR);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    icap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (cap_pin_i[i]),
      .sel_i (edge_sel_e'(sel[i])),
      .hit_o (hit[i])
    );
    icap_capture #(.W(CNT_W)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .hit_i (hit[i]),
      .cnt_i (cnt_i),
      .cap_o (cap[i])
    );
  end

  icap_csr u_csr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (csr_wr),
    .wdata_i (reg_wdata),
    .hit_i   (hit),
    .flag_o  (flag),
    .ie_o    (ie),
    .sel_o   (sel)
  );

  // flags read as one during a read-modify-write so the write-back keeps them
  assign csr_rd = {flag | {NCH{reg_rmw}}, ie, sel[1], sel[0]};

  always_comb begin
    unique case (reg_addr)
      ADDR_CSR:  reg_rdata = {{(CNT_W-8){1'b0}}, csr_rd};
      ADDR_CAP0: reg_rdata = cap[0];
      ADDR_CAP1: reg_rdata = cap[1];
      default:   reg_rdata = '0;
    endcase
  end

  assign irq_ch  = flag & ie;
  assign irq_any = |irq_ch;
endmodule

// File: rtl/icap_ctrl_chk.sv
module icap_ctrl_chk
  import icap_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_i,
  input logic [1:0]       reg_addr,
  input logic             reg_wr,
  input logic             reg_rmw,
  input logic [7:0]       reg_wdata,
  input logic [CNT_W-1:0] reg_rdata,
  input logic [NCH-1:0]   irq_ch,
  input logic [NCH-1:0]   hit,
  input logic [NCH-1:0]   flag,
  input logic [NCH-1:0]   ie,
  input logic [CNT_W-1:0] cap0,
  input logic [CNT_W-1:0] cap1
);
  AST_HIT_SETS_F0: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> flag[0]); // R11
  AST_HIT_SETS_F1: assert property (@(posedge clk) disable iff (!rst_n)
    hit[1] |=> flag[1]); // R11
  AST_FLAG_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag[0]) |-> $past(hit[0])); // R6
  AST_CAP_TRACKS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> (cap0 == $past(cnt_i))); // R7
  AST_ONE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_CSR && reg_wdata[FLAG_LSB] && flag[0]) |=> flag[0]); // R8
  AST_RMW_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rmw && reg_addr == ADDR_CSR) |-> (reg_rdata[7:6] == 2'b11)); // R9
  AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !ie[1] |-> !irq_ch[1]); // R10
  AST_CAP_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr != ADDR_CSR && !hit[1]) |=> $stable(cap1)); // R12
endmodule

bind icap_ctrl icap_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_i     (cnt_i),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rmw   (reg_rmw),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_ch    (irq_ch),
  .hit       (hit),
  .flag      (flag),
  .ie        (ie),
  .cap0      (cap[0]),
  .cap1      (cap[1])
);

// File: tb/icap_ctrl_tb.sv
module icap_ctrl_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_i = '0;
  logic [1:0]  cap_pin_i = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rmw = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  irq_ch;
  logic        irq_any;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  icap_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cap_pin_i(cap_pin_i),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rmw(reg_rmw),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_ch(irq_ch), .irq_any(irq_any)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic chk_reg(string req, logic [1:0] a, logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // change pins at a negedge, then wait until the result is visible (edge k+2)
  task automatic pins(logic [1:0] v, logic [15:0] c);
    @(negedge clk);
    cap_pin_i = v; cnt_i = c;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R2 csr", reg_rdata, 16'h0000);
    chk_reg("R2 cap0", 2'd1, 16'h0000);
    chk_reg("R2 cap1", 2'd2, 16'h0000);
    chk("R2 irq", {13'd0, irq_any, irq_ch}, 16'h0000);
    chk_reg("R1 addr3", 2'd3, 16'h0000);
  endtask

  task automatic t_rising;
    wr(2'd0, 8'h05);
    chk_reg("R1 csr readback", 2'd0, 16'h0005);
    @(negedge clk);
    cap_pin_i = 2'b01; cnt_i = 16'h1234;
    repeat (2) @(negedge clk);
    chk_reg("R7 not yet", 2'd0, 16'h0005);
    @(negedge clk);
    chk_reg("R7 flag on time", 2'd0, 16'h0045);
    chk_reg("R3 cap0", 2'd1, 16'h1234);
    chk_reg("R3 cap1 untouched", 2'd2, 16'h0000);
    pins(2'b00, 16'h5555);
    chk_reg("R3 falling ignored", 2'd1, 16'h1234);
    wr(2'd0, 8'h05);
    chk_reg("R8 cleared", 2'd0, 16'h0005);
  endtask

  task automatic t_falling;
    wr(2'd0, 8'h0A);
    pins(2'b10, 16'h2222);
    chk_reg("R4 rising ignored flag", 2'd0, 16'h000A);
    chk_reg("R4 rising ignored cap", 2'd2, 16'h0000);
    pins(2'b00, 16'h3333);
    chk_reg("R4 flag", 2'd0, 16'h008A);
    chk_reg("R4 cap1", 2'd2, 16'h3333);
    wr(2'd0, 8'h0A);
  endtask

  task automatic t_both;
    wr(2'd0, 8'h0F);
    pins(2'b01, 16'hAAAA);
    chk_reg("R5 rise flag", 2'd0, 16'h004F);
    chk_reg("R5 rise cap", 2'd1, 16'hAAAA);
    wr(2'd0, 8'h0F);
    pins(2'b00, 16'hBBBB);
    chk_reg("R5 fall flag", 2'd0, 16'h004F);
    chk_reg("R5 fall cap", 2'd1, 16'hBBBB);
    wr(2'd0, 8'h0F);
  endtask

  task automatic t_off;
    wr(2'd0, 8'h00);
    pins(2'b11, 16'hCCCC);
    chk_reg("R6 no flag", 2'd0, 16'h0000);
    chk_reg("R6 cap0 kept", 2'd1, 16'hBBBB);
    chk_reg("R6 cap1 kept", 2'd2, 16'h3333);
    pins(2'b00, 16'hDDDD);
    chk_reg("R6 no flag fall", 2'd0, 16'h0000);
  endtask

  task automatic t_clear;
    wr(2'd0, 8'h05);
    pins(2'b11, 16'h0101);
    chk_reg("R8 both set", 2'd0, 16'h00C5);
    wr(2'd0, 8'hC5);
    chk_reg("R8 ones keep", 2'd0, 16'h00C5);
    wr(2'd0, 8'h85);
    chk_reg("R8 clear ch0", 2'd0, 16'h0085);
    wr(2'd0, 8'h45);
    chk_reg("R8 one no set", 2'd0, 16'h0005);
    pins(2'b00, 16'h0000);
  endtask

  task automatic t_rmw;
    logic [15:0] d;
    wr(2'd0, 8'h35);
    reg_rmw = 1'b1;
    rd(2'd0, d);
    chk("R9 rmw read", d, 16'h00F5);
    reg_rmw = 1'b0;
    rd(2'd0, d);
    chk("R9 plain read", d, 16'h0035);
  endtask

  task automatic t_irq;
    wr(2'd0, 8'h15);
    pins(2'b11, 16'h0202);
    chk("R10 ch0 only", {14'd0, irq_ch}, 16'h0001);
    chk("R10 any", {15'd0, irq_any}, 16'h0001);
    wr(2'd0, 8'hE5);
    chk("R10 ch1 only", {14'd0, irq_ch}, 16'h0002);
    wr(2'd0, 8'hC5);
    chk("R10 none", {13'd0, irq_any, irq_ch}, 16'h0000);
    wr(2'd0, 8'h05);
    pins(2'b00, 16'h0000);
  endtask

  task automatic t_race;
    @(negedge clk);
    cap_pin_i = 2'b01; cnt_i = 16'h7777;
    @(negedge clk);
    @(negedge clk);
    reg_addr = 2'd0; reg_wdata = 8'h05; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk_reg("R11 set wins", 2'd0, 16'h0045);
    chk_reg("R11 cap", 2'd1, 16'h7777);
    wr(2'd0, 8'h05);
    pins(2'b00, 16'h0000);
  endtask

  task automatic t_ro;
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    chk_reg("R12 cap0", 2'd1, 16'h7777);
    chk_reg("R12 cap1", 2'd2, 16'h0202);
    chk_reg("R12 csr", 2'd0, 16'h0005);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_rising;
    t_falling;
    t_both;
    t_off;
    t_clear;
    t_rmw;
    t_irq;
    t_race;
    t_ro;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule